// File: doc/BRIEF.md
# Processor System Register Bank

This block holds the control and status registers of a processor core and gives them a single 5-bit index space of 32 slots. A move-to-register path writes a 32-bit word into the slot named by a write index. A move-from-register path returns the word held in the slot named by a read index. Every writable slot keeps only the bits its own write mask lets through. Masked bits always read back as zero.

The map is sparse. Ten architectural slots cover the exception and duplexed-exception PC/PSW pairs, the exception cause, the status word, the processor identifier, the task control word, the cache control word and the execution address trap. Three extra slots sit at the top of the map: a full-width scratch word, a read-only version constant and a single-bit flag. Any other index reads as zero, and writes to it are dropped. The live values of the writable registers are also driven on dedicated outputs for the rest of the core. Accesses to slots 29 to 31 depend on no execution address.

Top module: `sysreg_bank`

## Requirements
- R1: A write takes effect on the rising clock edge when `wr_en` is high. The read path is combinational, so a read of the index being written in that same cycle returns the value held before the edge.
- R2: Slot 29 stores all 32 bits of the write data and returns them unchanged. It is the only slot whose mask is all ones.
- R3: Slot 30 always reads 32'h0000_0004 (parameter `VERSION_ID`), and writes to it are discarded.
- R4: At slot 31 only bit 0 is stored and read back. Bits 31:1 always read zero.
- R5: Indices 8 to 23 and 26 to 28 always read zero. Writes to them change no slot and no output.
- R6: Each writable slot stores write data ANDed with its own mask. The default masks are: 0 and 2 (exception PCs) 32'hFFFF_FFFE; 1, 3 and 5 (exception PSWs and status) 32'h000F_F3FF; 4 (cause) 32'h0000_FFFF; 7 (task control) 32'h0000_01FF; 24 (cache control) 32'h0000_FFF3; 25 (trap address) 32'hFFFF_FFFE.
- R7: Slot 6 is read-only and returns parameter `CPU_ID` (default 32'h0000_8100). Writes to it are ignored.
- R8: A synchronous active-high reset clears every writable slot to zero. The exception is slot 5, which loads `STATUS_INIT` ANDed with its mask (default 32'h0000_8000).
- R9: The register outputs always equal the values held in slots 0, 1, 2, 3, 4, 5, 7, 24, 25, 29 and bit 0 of 31.
- R10: With `wr_en` low, no slot changes, whatever the write index and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Move-to-register enable |
| wr_idx | input | 5 | Slot index for the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 5 | Slot index for the read |
| rd_data | output | 32 | Read data, combinational |
| exc_pc_o | output | 32 | Exception/interrupt saved PC (slot 0) |
| exc_psw_o | output | 32 | Exception/interrupt saved PSW (slot 1) |
| dup_pc_o | output | 32 | Duplexed-exception saved PC (slot 2) |
| dup_psw_o | output | 32 | Duplexed-exception saved PSW (slot 3) |
| cause_o | output | 32 | Exception cause (slot 4) |
| status_o | output | 32 | Program status word (slot 5) |
| task_ctl_o | output | 32 | Task control word (slot 7) |
| cache_ctl_o | output | 32 | Cache control word (slot 24) |
| trap_addr_o | output | 32 | Execution address trap (slot 25) |
| scratch_o | output | 32 | Scratch word (slot 29) |
| aux_bit_o | output | 1 | Single-bit flag (slot 31) |

## Verification
The hardest case to reach from the ports is a read and a write of the same index in the same cycle. Two faults look alike here. A design that forwards the new data is wrong. A design that fails to store the data is also wrong. Telling them apart needs the old value and the new value to differ in bits the mask keeps. The stimulus therefore writes a value, then overwrites it with its complement while reading that same index, and checks the complement on the next cycle. Long random traffic forces the read index to equal the write index on a large share of cycles. A bench model compares every cycle against the per-slot masks, so a wrong mask bit in any slot is also exposed.

// File: rtl/sysreg_bank.sv
module sysreg_bank #(
  parameter logic [31:0] CPU_ID      = 32'h0000_8100,
  parameter logic [31:0] VERSION_ID  = 32'h0000_0004,
  parameter logic [31:0] STATUS_INIT = 32'h0000_8000,
  parameter logic [31:0] M_EXC_PC    = 32'hFFFF_FFFE,
  parameter logic [31:0] M_EXC_PSW   = 32'h000F_F3FF,
  parameter logic [31:0] M_DUP_PC    = 32'hFFFF_FFFE,
  parameter logic [31:0] M_DUP_PSW   = 32'h000F_F3FF,
  parameter logic [31:0] M_CAUSE     = 32'h0000_FFFF,
  parameter logic [31:0] M_STATUS    = 32'h000F_F3FF,
  parameter logic [31:0] M_TASK      = 32'h0000_01FF,
  parameter logic [31:0] M_CACHE     = 32'h0000_FFF3,
  parameter logic [31:0] M_TRAP      = 32'hFFFF_FFFE,
  parameter logic [31:0] M_SCRATCH   = 32'hFFFF_FFFF,
  parameter logic [31:0] M_AUX       = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [4:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_idx,
  output logic [31:0] rd_data,
  output logic [31:0] exc_pc_o,
  output logic [31:0] exc_psw_o,
  output logic [31:0] dup_pc_o,
  output logic [31:0] dup_psw_o,
  output logic [31:0] cause_o,
  output logic [31:0] status_o,
  output logic [31:0] task_ctl_o,
  output logic [31:0] cache_ctl_o,
  output logic [31:0] trap_addr_o,
  output logic [31:0] scratch_o,
  output logic        aux_bit_o
);

  localparam int SLOTS = 32;
  localparam logic [4:0] IDX_STATUS = 5'd5;
  localparam logic [4:0] IDX_CPUID  = 5'd6;
  localparam logic [4:0] IDX_VER    = 5'd30;

  function automatic logic [31:0] slot_mask(input logic [4:0] i);
    case (i)
      5'd0:    slot_mask = M_EXC_PC;
      5'd1:    slot_mask = M_EXC_PSW;
      5'd2:    slot_mask = M_DUP_PC;
      5'd3:    slot_mask = M_DUP_PSW;
      5'd4:    slot_mask = M_CAUSE;
      5'd5:    slot_mask = M_STATUS;
      5'd7:    slot_mask = M_TASK;
      5'd24:   slot_mask = M_CACHE;
      5'd25:   slot_mask = M_TRAP;
      5'd29:   slot_mask = M_SCRATCH;
      5'd31:   slot_mask = M_AUX;
      default: slot_mask = 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] slot_init(input logic [4:0] i);
    slot_init = (i == IDX_STATUS) ? (STATUS_INIT & M_STATUS) : 32'h0;
  endfunction

  logic [31:0] slot_q [SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= slot_init(5'(i));
    end else if (wr_en) begin
      slot_q[wr_idx] <= wr_data & slot_mask(wr_idx);
    end
  end

  assign rd_data = (rd_idx == IDX_CPUID) ? CPU_ID :
                   (rd_idx == IDX_VER)   ? VERSION_ID :
                   slot_q[rd_idx];

  assign exc_pc_o    = slot_q[0];
  assign exc_psw_o   = slot_q[1];
  assign dup_pc_o    = slot_q[2];
  assign dup_psw_o   = slot_q[3];
  assign cause_o     = slot_q[4];
  assign status_o    = slot_q[5];
  assign task_ctl_o  = slot_q[7];
  assign cache_ctl_o = slot_q[24];
  assign trap_addr_o = slot_q[25];
  assign scratch_o   = slot_q[29];
  assign aux_bit_o   = slot_q[31][0];

endmodule

module sysreg_bank_chk #(
  parameter logic [31:0] CPU_ID     = 32'h0000_8100,
  parameter logic [31:0] VERSION_ID = 32'h0000_0004
) (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [4:0]  wr_idx,
  input logic [31:0] wr_data,
  input logic [4:0]  rd_idx,
  input logic [31:0] rd_data,
  input logic [31:0] status_o,
  input logic [31:0] scratch_o,
  input logic        aux_bit_o
);

  // R5
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_idx inside {[5'd8:5'd23], [5'd26:5'd28]}) |-> rd_data == 32'h0);

  // R3
  version_const_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == 5'd30) |-> rd_data == VERSION_ID);

  // R7
  cpu_id_const_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == 5'd6) |-> rd_data == CPU_ID);

  // R4
  aux_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == 5'd31) |-> rd_data[31:1] == 31'h0);

  // R2
  scratch_full_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 5'd29) |=> scratch_o == $past(wr_data));

  // R4
  aux_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 5'd31) |=> aux_bit_o == $past(wr_data[0]));

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == 5'd5) |=> $stable(status_o));

endmodule

bind sysreg_bank sysreg_bank_chk #(.CPU_ID(CPU_ID), .VERSION_ID(VERSION_ID)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_idx(rd_idx), .rd_data(rd_data), .status_o(status_o),
  .scratch_o(scratch_o), .aux_bit_o(aux_bit_o)
);

// File: tb/sysreg_bank_test.sv
`timescale 1ns/1ps
module sysreg_bank_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [4:0] wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0] rd_idx = '0;
  logic [31:0] rd_data, exc_pc_o, exc_psw_o, dup_pc_o, dup_psw_o, cause_o, status_o;
  logic [31:0] task_ctl_o, cache_ctl_o, trap_addr_o, scratch_o;
  logic aux_bit_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [32];
  bit done = 0;

  always #2.5 clk = ~clk;

  sysreg_bank uut (.*);

  function automatic logic [31:0] ref_mask(int i);
    case (i)
      0, 2, 25: return 32'hFFFF_FFFE;
      1, 3, 5:  return 32'h000F_F3FF;
      4:        return 32'h0000_FFFF;
      7:        return 32'h0000_01FF;
      24:       return 32'h0000_FFF3;
      29:       return 32'hFFFF_FFFF;
      31:       return 32'h0000_0001;
      default:  return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] ref_read(int i);
    if (i == 6) return 32'h0000_8100;
    if (i == 30) return 32'h0000_0004;
    return model[i];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    check(req, exc_pc_o, model[0]);
    check(req, exc_psw_o, model[1]);
    check(req, dup_pc_o, model[2]);
    check(req, dup_psw_o, model[3]);
    check(req, cause_o, model[4]);
    check(req, status_o, model[5]);
    check(req, task_ctl_o, model[7]);
    check(req, cache_ctl_o, model[24]);
    check(req, trap_addr_o, model[25]);
    check(req, scratch_o, model[29]);
    check(req, {31'h0, aux_bit_o}, {31'h0, model[31][0]});
  endtask

  // one cycle: drive at negedge, check read before the edge, update model, check outputs after
  task automatic step(bit we, int widx, logic [31:0] wd, int ridx, string req);
    wr_en = we; wr_idx = 5'(widx); wr_data = wd; rd_idx = 5'(ridx);
    #1;
    check(req, rd_data, ref_read(ridx));
    @(posedge clk);
    if (we) model[widx] = wd & ref_mask(widx);
    @(negedge clk);
    check_outputs(req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    model[5] = 32'h0000_8000;
    // hold reset with a write pending: R8
    wr_en = 1'b1; wr_idx = 5'd29; wr_data = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wr_en = 1'b0;
    // R8 reset state of every slot
    for (int i = 0; i < 32; i++) step(0, 0, 32'h0, i, "R8");

    // R6 R2 R3 R4 R5 R7: all ones into every slot, read back
    for (int i = 0; i < 32; i++) step(1, i, 32'hFFFF_FFFF, i, "R6");
    for (int i = 0; i < 32; i++) step(0, 0, 32'h0, i, "R6");
    step(0, 0, 32'h0, 29, "R2");
    step(0, 0, 32'h0, 30, "R3");
    step(0, 0, 32'h0, 31, "R4");
    step(0, 0, 32'h0, 6, "R7");
    step(0, 0, 32'h0, 8, "R5");
    step(0, 0, 32'h0, 28, "R5");

    // R2 pattern
    step(1, 29, 32'h1234_5678, 29, "R2");
    step(0, 0, 32'h0, 29, "R2");
    // R4 zero into flag
    step(1, 31, 32'hFFFF_FFFE, 31, "R4");
    step(0, 0, 32'h0, 31, "R4");

    // R1 same-cycle read returns old value; next cycle returns new
    step(1, 5, 32'h000A_5155, 5, "R1");
    step(1, 5, 32'hFFF5_AEAA, 5, "R1");
    step(0, 0, 32'h0, 5, "R1");

    // R10 enable low: nothing changes
    for (int i = 0; i < 32; i++) step(0, i, 32'h5555_AAAA, i, "R10");

    // R5 writes to unmapped slots leave everything unchanged
    for (int i = 8; i < 24; i++) step(1, i, 32'hFFFF_FFFF, i, "R5");
    for (int i = 26; i < 29; i++) step(1, i, 32'hFFFF_FFFF, i, "R5");
    // R3 R7 writes discarded
    step(1, 30, 32'h0, 30, "R3");
    step(1, 6, 32'h0, 6, "R7");

    // R9 random traffic, read index often equals write index
    for (int n = 0; n < 3000; n++) begin
      int wi = $urandom_range(0, 31);
      int ri = ($urandom_range(0, 1) == 1) ? wi : $urandom_range(0, 31);
      step($urandom_range(0, 3) != 0, wi, $urandom, ri, "R9");
    end

    // R8 reset again mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    model[5] = 32'h0000_8000;
    for (int i = 0; i < 32; i++) step(0, 0, 32'h0, i, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule